// File: doc/BRIEF.md
# I2C Slave Address and General-Call Detector

This block watches the first byte that an I2C slave receives after a START or a repeated START condition. It decides whether the device is being addressed. The device counts as addressed when the upper seven bits of that byte equal the programmed own address, or when the byte is a general call (all zeros). A free-data-format select skips the address compare: any first word then marks the device as addressed. Two sticky flags are kept. The addressed flag is cleared by processor access to the data buffer. The general-call flag is cleared by bus START or STOP events.

The block also follows the SCL clock. On every SCL rising edge it captures SDA as the last received bit. On the ninth rising edge of each frame it raises a one-cycle byte-complete interrupt. Because of this, the acknowledge bit is visible on the last-bit output in the same cycle as the interrupt. The received byte arrives as a plain strobe with data. The block accepts every strobe in the cycle it is presented, so it never applies back-pressure and has no ready signal. The surrounding logic provides START/STOP detection, the shift register and acknowledge driving.

Top module: `i2c_slave_addr_detect`

## Requirements
- R1: After reset, `addressed` is 0. It becomes 1 in the cycle after a `rx_valid` strobe that meets all of these conditions: it carries the first byte since the last `start_pulse`, `slave_mode` is 1, `free_fmt` is 0, and `rx_byte[7:1]` equals `own_addr`. The value of `rx_byte[0]` is the direction bit and does not matter. With `slave_mode` at 0 the flag is not set.
- R2: With `free_fmt` at 0 and `slave_mode` at 1, a first byte of 8'h00 also sets `addressed`, whatever the value of `own_addr`.
- R3: With `free_fmt` at 1 and `slave_mode` at 1, any first byte sets `addressed`, with no address compare.
- R4: A cycle with `buf_rd` or `buf_wr` at 1 clears `addressed` on the next cycle. If a set condition from R1 to R3 falls in the same cycle, the set wins.
- R5: After reset, `gen_call` is 0. It becomes 1 in the cycle after a first byte of 8'h00 is received with `slave_mode` at 1. This holds for either value of `free_fmt`.
- R6: `start_pulse` or `stop_pulse` clears `gen_call` on the next cycle, and the clear wins over a set in the same cycle. A `rx_valid` strobe in the same cycle as `start_pulse` is not evaluated.
- R7: After reset, `last_bit` is 0. A rising edge of SCL is a cycle in which `scl_sync` is 1 and was 0 in the previous cycle. The idle level before the first edge counts as 1. On each rising edge, `last_bit` takes the value of `sda_sync` from that cycle, and the new value is visible in the next cycle.
- R8: `byte_irq` is 1 for exactly one cycle. That cycle is the one after the ninth SCL rising edge counted since the last START or STOP, so the acknowledge bit appears on `last_bit` in the same cycle. The count then starts again.
- R9: Only the first `rx_valid` strobe after a START is evaluated. Later strobes, and any strobe after a STOP that has no new START, leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_sync | input | 1 | Synchronized SCL level |
| sda_sync | input | 1 | Synchronized SDA level |
| start_pulse | input | 1 | One-cycle START / repeated START detect |
| stop_pulse | input | 1 | One-cycle STOP detect |
| rx_valid | input | 1 | Byte-complete strobe for `rx_byte` |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| own_addr | input | 7 | Programmed own slave address |
| free_fmt | input | 1 | 1 selects the free data format (no address compare) |
| slave_mode | input | 1 | 1 when the controller acts as a slave |
| buf_rd | input | 1 | Processor read of the data buffer |
| buf_wr | input | 1 | Processor write of the data buffer |
| addressed | output | 1 | Sticky addressed-as-slave flag |
| gen_call | output | 1 | Sticky general-call flag |
| last_bit | output | 1 | SDA level captured at the latest SCL rising edge |
| byte_irq | output | 1 | One-cycle pulse at the ninth SCL rising edge |

## Verification
Suppose the first-byte tracking state is wrong, for example a frame left open after a STOP or never reopened by a START. This shows up at the ports one cycle after the next `rx_valid` strobe, as an `addressed` or `gen_call` value that differs from the frame history. A bit counter that is off by one moves `byte_irq` away from the ninth rising edge, so the acknowledge bit no longer appears on `last_bit` in the interrupt cycle. This is visible within the first frame. Each output is compared against a bench model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/i2c_sad_pkg.sv
package i2c_sad_pkg;

  // Detection outcome for the byte presented in the current cycle.
  typedef struct packed {
    logic addr_set;  // raise the addressed flag
    logic gc_set;    // raise the general-call flag
  } det_t;

  // True when every bit of a byte is zero (general-call pattern).
  function automatic logic all_zero8(input logic [7:0] b);
    return (b == 8'h00);
  endfunction

endpackage

// File: rtl/i2c_sad_scl_tracker.sv
module i2c_sad_scl_tracker #(
  parameter int BITS_PER_FRAME = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  input  logic frame_rst,
  output logic last_bit,
  output logic frame_done
);
  localparam int CNT_W = $clog2(BITS_PER_FRAME);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BITS_PER_FRAME - 1);

  logic             scl_q;
  logic             scl_rise;
  logic [CNT_W-1:0] bit_cnt;

  assign scl_rise = scl & ~scl_q;

  // Previous SCL level; the bus idles high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl;
  end

  // SDA captured at every rising edge of SCL.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_bit <= 1'b0;
    else if (scl_rise) last_bit <= sda;
  end

  // Bit position within the frame, with the end-of-frame pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (frame_rst) begin
        bit_cnt <= '0;
      end else if (scl_rise) begin
        if (bit_cnt == LAST_IDX) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_sad_first_byte.sv
module i2c_sad_first_byte
  import i2c_sad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              free_fmt,
  input  logic              slave_mode,
  output det_t              det
);
  logic first_open;
  logic eval;
  logic addr_hit;
  logic zero_byte;

  // A frame is open from START until its first byte or a STOP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          first_open <= 1'b0;
    else if (start_pulse) first_open <= 1'b1;
    else if (stop_pulse)  first_open <= 1'b0;
    else if (rx_valid)    first_open <= 1'b0;
  end

  assign eval      = rx_valid & first_open & ~start_pulse & slave_mode;
  assign addr_hit  = (rx_byte[DATA_W-1 -: ADDR_W] == own_addr);
  assign zero_byte = all_zero8(8'(rx_byte));

  always_comb begin
    det          = '0;
    det.gc_set   = eval & zero_byte;
    det.addr_set = eval & (free_fmt | addr_hit | zero_byte);
  end
endmodule

// File: rtl/i2c_sad_flags.sv
module i2c_sad_flags
  import i2c_sad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  det_t det,
  input  logic bus_event,
  input  logic buf_access,
  output logic addressed,
  output logic gen_call
);
  // Addressed flag: a set wins over a buffer access in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addressed <= 1'b0;
    else if (det.addr_set) addressed <= 1'b1;
    else if (buf_access)   addressed <= 1'b0;
  end

  // General-call flag: a START/STOP clear wins over a set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gen_call <= 1'b0;
    else if (bus_event)  gen_call <= 1'b0;
    else if (det.gc_set) gen_call <= 1'b1;
  end
endmodule

// File: rtl/i2c_slave_addr_detect.sv
module i2c_slave_addr_detect
  import i2c_sad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_sync,
  input  logic              sda_sync,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              free_fmt,
  input  logic              slave_mode,
  input  logic              buf_rd,
  input  logic              buf_wr,
  output logic              addressed,
  output logic              gen_call,
  output logic              last_bit,
  output logic              byte_irq
);
  localparam int BITS_PER_FRAME = DATA_W + 1;  // data bits plus acknowledge

  det_t det;
  logic bus_event;

  assign bus_event = start_pulse | stop_pulse;

  i2c_sad_scl_tracker #(.BITS_PER_FRAME(BITS_PER_FRAME)) trk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl        (scl_sync),
    .sda        (sda_sync),
    .frame_rst  (bus_event),
    .last_bit   (last_bit),
    .frame_done (byte_irq)
  );

  i2c_sad_first_byte #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) fb_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .own_addr    (own_addr),
    .free_fmt    (free_fmt),
    .slave_mode  (slave_mode),
    .det         (det)
  );

  i2c_sad_flags flg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .det        (det),
    .bus_event  (bus_event),
    .buf_access (buf_rd | buf_wr),
    .addressed  (addressed),
    .gen_call   (gen_call)
  );
endmodule

// File: rtl/i2c_sad_chk.sv
module i2c_sad_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_sync,
  input logic              sda_sync,
  input logic              start_pulse,
  input logic              stop_pulse,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              slave_mode,
  input logic              buf_rd,
  input logic              buf_wr,
  input logic              addressed,
  input logic              gen_call,
  input logic              last_bit,
  input logic              byte_irq
);
  AST_NO_SET_OUTSIDE_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !addressed) |=> !addressed); // R1
  AST_ACCESS_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ((buf_rd || buf_wr) && !rx_valid) |=> !addressed); // R4
  AST_GC_NEEDS_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_call && rx_valid && rx_byte != '0) |=> !gen_call); // R5
  AST_BUS_EVENT_CLEARS_GC: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || stop_pulse) |=> !gen_call); // R6
  AST_LAST_BIT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !scl_sync) ##1 scl_sync |=> (last_bit == $past(sda_sync))); // R7
  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |=> !byte_irq); // R8
  AST_LATE_BYTE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !start_pulse) ##1 (rx_valid && !start_pulse && !buf_rd && !buf_wr)
      |=> $stable(addressed)); // R9
endmodule

bind i2c_slave_addr_detect i2c_sad_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/i2c_slave_addr_detect_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_addr_detect_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       scl = 1'b1, sda = 1'b1, st = 1'b0, sp = 1'b0, rv = 1'b0;
  logic [7:0] b = 8'h00;
  logic [6:0] own = 7'h2A;
  logic       ff = 1'b0, sm = 1'b1, rd = 1'b0, wr = 1'b0;
  logic       addressed, gen_call, last_bit, byte_irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Expected state
  bit e_addr, e_gc, e_last, e_irq, prev_scl, fopen;
  int cnt;

  i2c_slave_addr_detect dut_i (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl), .sda_sync(sda),
    .start_pulse(st), .stop_pulse(sp), .rx_valid(rv), .rx_byte(b),
    .own_addr(own), .free_fmt(ff), .slave_mode(sm), .buf_rd(rd), .buf_wr(wr),
    .addressed(addressed), .gen_call(gen_call), .last_bit(last_bit),
    .byte_irq(byte_irq)
  );

  function automatic bit addr_cond(input logic [7:0] by, input logic [6:0] oa,
                                   input logic f);
    return f || (by[7:1] == oa) || (by == 8'h00);
  endfunction

  task automatic model();
    bit rise, ev;
    rise = scl && !prev_scl;
    prev_scl = scl;
    e_irq = 1'b0;
    if (rise) e_last = sda;
    if (st || sp) cnt = 0;
    else if (rise) begin
      if (cnt == 8) begin cnt = 0; e_irq = 1'b1; end
      else cnt++;
    end
    ev = rv && fopen && !st && sm;
    if (ev && addr_cond(b, own, ff)) e_addr = 1'b1;
    else if (rd || wr) e_addr = 1'b0;
    if (st || sp) e_gc = 1'b0;
    else if (ev && b == 8'h00) e_gc = 1'b1;
    if (st) fopen = 1'b1;
    else if (sp || rv) fopen = 1'b0;
  endtask

  task automatic cmp(input string tag, input string nm, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic tick(input string ta = "R1", input string tg = "R5");
    @(posedge clk);
    model();
    @(negedge clk);
    cmp(ta, "addressed", addressed, e_addr);
    cmp(tg, "gen_call", gen_call, e_gc);
    cmp("R7", "last_bit", last_bit, e_last);
    cmp("R8", "byte_irq", byte_irq, e_irq);
    st = 0; sp = 0; rv = 0; rd = 0; wr = 0;
  endtask

  task automatic clock_bit(input logic v);
    scl = 1'b0; sda = v; tick();
    scl = 1'b1; tick();
  endtask

  // One frame: START, 9 bits (8 data plus ack), byte strobe.
  task automatic frame(input logic [7:0] by, input logic ack,
                       input string ta, input string tg);
    st = 1; tick(ta, tg);
    for (int i = 7; i >= 0; i--) clock_bit(by[i]);
    clock_bit(ack);
    rv = 1; b = by; tick(ta, tg);
  endtask

  initial begin
    prev_scl = 1; cnt = 0; fopen = 0;
    e_addr = 0; e_gc = 0; e_last = 0; e_irq = 0;
    repeat (3) @(negedge clk);
    // R10-style reset check is carried by R1/R5/R7/R8 reset values
    cmp("R1", "addressed after reset", addressed, 1'b0);
    cmp("R5", "gen_call after reset", gen_call, 1'b0);
    cmp("R7", "last_bit after reset", last_bit, 1'b0);
    rst_n = 1'b1;
    tick();

    // R1: own-address match, direction bit set
    frame({own, 1'b1}, 1'b0, "R1", "R5");
    cmp("R1", "match sets addressed", addressed, 1'b1);
    rd = 1; tick("R4", "R5");
    cmp("R4", "read clears addressed", addressed, 1'b0);
    // R1: not slave mode
    sm = 0; frame({own, 1'b0}, 1'b1, "R1", "R5");
    cmp("R1", "no set outside slave mode", addressed, 1'b0);
    sm = 1;
    // R2 and R5: general call
    frame(8'h00, 1'b0, "R2", "R5");
    cmp("R2", "general call sets addressed", addressed, 1'b1);
    cmp("R5", "general call flag", gen_call, 1'b1);
    // R9: second byte in same transfer (mismatch) leaves flags
    wr = 1; tick("R4", "R5");
    rv = 1; b = 8'h00; tick("R9", "R9");
    cmp("R9", "late byte ignored", addressed, 1'b0);
    // R6: STOP clears general call
    sp = 1; tick("R1", "R6");
    cmp("R6", "stop clears gen_call", gen_call, 1'b0);
    rv = 1; b = {own, 1'b0}; tick("R9", "R9");
    cmp("R9", "byte after stop ignored", addressed, 1'b0);
    // R6: START clears gen_call; start with strobe is not evaluated
    frame(8'h00, 1'b1, "R2", "R5");
    st = 1; rv = 1; b = 8'h00; tick("R6", "R6");
    cmp("R6", "start clears gen_call", gen_call, 1'b0);
    rd = 1; tick("R4", "R6");
    // R3: free format with mismatching byte
    ff = 1; frame(8'hC3, 1'b0, "R3", "R5");
    cmp("R3", "free format sets addressed", addressed, 1'b1);
    ff = 0;
    // R4: set and access in the same cycle, set wins
    rd = 1; tick("R4", "R5");
    st = 1; tick();
    rv = 1; b = {own, 1'b0}; wr = 1; tick("R4", "R5");
    cmp("R4", "set wins over access", addressed, 1'b1);
    // R8: ack bit visible with irq
    st = 1; tick();
    for (int i = 0; i < 8; i++) clock_bit(1'b1);
    scl = 1'b0; sda = 1'b0; tick();
    scl = 1'b1; tick();
    cmp("R8", "irq on ninth rise", byte_irq, 1'b1);
    cmp("R8", "ack visible with irq", last_bit, 1'b0);

    // Constrained random frames
    for (int f = 0; f < 400; f++) begin
      int k;
      logic [7:0] by;
      k = $urandom_range(0, 3);
      by = (k == 0) ? {own, 1'($urandom)} : (k == 1) ? 8'h00 : 8'($urandom);
      ff = ($urandom_range(0, 4) == 0);
      sm = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 3) == 0) own = 7'($urandom);
      frame(by, 1'($urandom), "R1", "R5");
      if ($urandom_range(0, 2) == 0) begin rv = 1; b = 8'($urandom_range(0, 1)); tick("R9", "R9"); end
      if ($urandom_range(0, 2) == 0) begin rd = 1'($urandom); wr = ~rd; tick("R4", "R5"); end
      if ($urandom_range(0, 3) == 0) begin sp = 1; tick("R1", "R6"); end
      for (int j = $urandom_range(0, 5); j > 0; j--) begin
        scl = 1'($urandom); sda = 1'($urandom); tick();
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule